// File: doc/BRIEF.md
# External Interrupt Trigger Detector

This block watches one active-low external interrupt pin and turns it into a request flag for an interrupt controller. The pin is first brought into the clock domain through a chain of synchronizer flops. The synchronized value is then sampled only in cycles where the machine-cycle strobe is high. A mode input chooses how the sampled pin becomes a request.

In level mode, the request follows the inverted sampled pin. It stays asserted for as long as the pin is seen low, so a source that is still low after service raises a new request. In edge mode, a high sample followed by a low sample on the next strobe sets a sticky flag. The controller's acknowledge clears that flag. Software can also write the flag in edge mode, and it reads the flag on the `req` output.

Top module: `ext_irq_trigger`

## Requirements
- R1: After reset, `req` is 0, and the block behaves as if the pin had last been sampled high. Level mode (`edge_mode` = 0) is the default that the integrating logic provides.
- R2: In level mode, `req` equals the inverse of the most recent strobe sample. A pin change at the input shows on `req` at the third rising clock edge, provided `mc_strobe` is high at that edge.
- R3: In edge mode, a strobe sample of 1 followed by a strobe sample of 0 sets the flag. The flag then stays set after the pin returns high.
- R4: In level mode, a pin that goes low and then returns high before any acknowledge leaves `req` at 0 once the high level has been sampled.
- R5: In level mode, `ack` has no effect: a pin still low after an acknowledge keeps `req` at 1.
- R6: In edge mode, `ack` = 1 clears the flag at the next edge, unless a falling edge is detected or a software write occurs in the same cycle.
- R7: A falling edge detected in the same cycle as `ack` leaves the flag set.
- R8: The pin is sampled only at edges where `mc_strobe` = 1. A pin low-pulse that lies wholly between strobes sets no flag and raises no request.
- R9: In edge mode, `sw_wr` = 1 loads `sw_wdata` into the flag. A detected edge takes priority over the write, and the write takes priority over `ack`. In level mode, a write has no effect on `req`, and the edge flag is held at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| pin_n | input | 1 | External interrupt pin, active low, asynchronous |
| mc_strobe | input | 1 | Machine-cycle sample strobe |
| edge_mode | input | 1 | 1 = falling-edge trigger, 0 = low-level trigger |
| ack | input | 1 | Controller acknowledge of this vector |
| sw_wr | input | 1 | Software write strobe for the flag |
| sw_wdata | input | 1 | Software write value |
| req | output | 1 | Interrupt request, also the software read value of the flag |

## Verification
The bench places an acknowledge in exactly the cycle where a new falling edge is detected. A design that lets the clear win there would lose the second interrupt. It also puts a low pulse wholly between strobes, which a design that samples every cycle would wrongly latch. The level-mode tests confirm that an acknowledge does not hide a pin that is still low, and that a pin released before service leaves no request. A design that latched in level mode would fail both. A software write made in level mode must have no visible effect, and a write in edge mode must be able to both set and clear the flag.

// File: rtl/ext_irq_trigger.sv
module ext_irq_trigger #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_n,
  input  logic mc_strobe,
  input  logic edge_mode,
  input  logic ack,
  input  logic sw_wr,
  input  logic sw_wdata,
  output logic req
);

  localparam int SW = (SYNC_STAGES < 2) ? 2 : SYNC_STAGES;

  logic [SW-1:0] sync_q;
  logic          pin_s;
  logic          samp_q;
  logic          flag_q;
  logic          fall_hit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '1;
    else        sync_q <= {sync_q[SW-2:0], pin_n};
  end

  assign pin_s = sync_q[SW-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         samp_q <= 1'b1;
    else if (mc_strobe) samp_q <= pin_s;
  end

  assign fall_hit = mc_strobe & edge_mode & samp_q & ~pin_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          flag_q <= 1'b0;
    else if (!edge_mode) flag_q <= 1'b0;
    else if (fall_hit)   flag_q <= 1'b1;
    else if (sw_wr)      flag_q <= sw_wdata;
    else if (ack)        flag_q <= 1'b0;
  end

  assign req = edge_mode ? flag_q : ~samp_q;

  // Level-mode request moves only on a strobe.
  assert_level_gated_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!edge_mode && !mc_strobe) |=> (edge_mode || $stable(req)));

  // The edge flag holds until ack or write.
  assert_edge_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (edge_mode && req && !ack && !sw_wr) |=> (!edge_mode || req));

  // An acknowledge with no strobe and no write clears the flag.
  assert_ack_clears_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (edge_mode && ack && !sw_wr && !mc_strobe) |=> (!edge_mode || !req));

  // With no strobe, no edge can be detected.
  assert_no_strobe_no_set_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (edge_mode && !req && !mc_strobe && !sw_wr) |=> (!edge_mode || !req));

  // A write in edge mode with no strobe loads the written value.
  assert_sw_load_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (edge_mode && sw_wr && !mc_strobe) |=> (!edge_mode || req == $past(sw_wdata)));

endmodule

// File: tb/ext_irq_trigger_tb.sv
module ext_irq_trigger_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic pin_n = 1'b1;
  logic mc_strobe = 1'b1;
  logic edge_mode = 1'b0;
  logic ack = 1'b0;
  logic sw_wr = 1'b0;
  logic sw_wdata = 1'b0;
  logic req;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  ext_irq_trigger u_dut (
    .clk(clk), .rst_n(rst_n), .pin_n(pin_n), .mc_strobe(mc_strobe),
    .edge_mode(edge_mode), .ack(ack), .sw_wr(sw_wr), .sw_wdata(sw_wdata),
    .req(req)
  );

  task automatic chk(input logic exp, input string tag);
    checks++;
    if (req !== exp) begin
      errors++;
      $display("FAIL %s: req=%b expected %b", tag, req, exp);
    end
  endtask

  task automatic tick(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic settle_high();
    mc_strobe = 1'b1; ack = 1'b0; sw_wr = 1'b0; pin_n = 1'b1;
    tick(4);
  endtask

  task automatic t_reset();
    chk(1'b0, "R1 reset req");
  endtask

  task automatic t_level_follow();
    edge_mode = 1'b0; settle_high();
    pin_n = 1'b0;
    tick(2); chk(1'b0, "R2 level before latency");
    tick(1); chk(1'b1, "R2 level asserted at third edge");
    pin_n = 1'b1;
    tick(3); chk(1'b0, "R4 level released before service");
  endtask

  task automatic t_level_still_low();
    edge_mode = 1'b0; settle_high();
    pin_n = 1'b0; tick(3);
    ack = 1'b1; tick(1); ack = 1'b0; tick(1);
    chk(1'b1, "R5 level re-request after ack");
    pin_n = 1'b1; tick(3);
    chk(1'b0, "R5 level drops after release");
  endtask

  task automatic t_edge_latch();
    edge_mode = 1'b1; settle_high();
    chk(1'b0, "R3 edge idle");
    pin_n = 1'b0;
    tick(2); chk(1'b0, "R3 edge before latency");
    tick(1); chk(1'b1, "R3 edge flag set");
    pin_n = 1'b1; tick(4);
    chk(1'b1, "R3 flag sticky after pin high");
    ack = 1'b1; tick(1); ack = 1'b0;
    chk(1'b0, "R6 ack clears flag");
  endtask

  task automatic t_ack_collide();
    edge_mode = 1'b1; settle_high();
    sw_wr = 1'b1; sw_wdata = 1'b1; tick(1); sw_wr = 1'b0;
    chk(1'b1, "R9 write sets flag");
    pin_n = 1'b0; tick(2);
    ack = 1'b1; tick(1); ack = 1'b0;
    chk(1'b1, "R7 edge beats ack");
    ack = 1'b1; tick(1); ack = 1'b0;
    chk(1'b0, "R6 later ack clears");
    pin_n = 1'b1; tick(3);
  endtask

  task automatic t_strobe_gating();
    edge_mode = 1'b1; settle_high();
    mc_strobe = 1'b0;
    pin_n = 1'b0; tick(5);
    chk(1'b0, "R8 no strobe no flag");
    pin_n = 1'b1; tick(4);
    mc_strobe = 1'b1; tick(3);
    chk(1'b0, "R8 pulse between strobes ignored");
    mc_strobe = 1'b0;
    pin_n = 1'b0; tick(4);
    mc_strobe = 1'b1; tick(1); mc_strobe = 1'b0;
    chk(1'b1, "R8 edge seen on strobe sample");
    pin_n = 1'b1; mc_strobe = 1'b1;
    ack = 1'b1; tick(1); ack = 1'b0; tick(3);
  endtask

  task automatic t_sw_access();
    edge_mode = 1'b1; settle_high();
    sw_wr = 1'b1; sw_wdata = 1'b1; tick(1);
    sw_wdata = 1'b0; tick(1); sw_wr = 1'b0;
    chk(1'b0, "R9 write clears flag");
    sw_wr = 1'b1; sw_wdata = 1'b1; ack = 1'b1; tick(1);
    sw_wr = 1'b0; ack = 1'b0;
    chk(1'b1, "R9 write beats ack");
    edge_mode = 1'b0; tick(1);
    sw_wr = 1'b1; sw_wdata = 1'b1; tick(1); sw_wr = 1'b0;
    chk(1'b0, "R9 level mode ignores write");
    pin_n = 1'b0; tick(3); pin_n = 1'b1; tick(3);
    edge_mode = 1'b1; tick(1);
    chk(1'b0, "R9 level mode left no edge flag");
  endtask

  initial begin
    tick(3);
    rst_n = 1'b1;
    tick(1);
    t_reset();
    t_level_follow();
    t_level_still_low();
    t_edge_latch();
    t_ack_collide();
    t_strobe_gating();
    t_sw_access();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (5000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog: run hung, actual timeout expected completion");
      end
    join_any
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule